// File: doc/BRIEF.md
# Receive Queue Register Port

This block places a receive queue behind a small register bus. Words arrive on an ingress port with a valid strobe and are stored in order. Software sees the queue through three registers: a data register, a level register and a status register. Reading the data register is an operation, not an observation. The read returns the oldest stored word and removes it from the queue in the same access, so the level and the empty flag change as a consequence of the read.

A separate peek output always shows the word at the head of the queue without consuming it. Debug or monitoring logic can watch the queue through this output without draining it.

The status register holds four bits:
- an empty flag;
- a full flag;
- a sticky underflow bit, set by reading an empty queue;
- a sticky overflow bit, set by pushing into a full queue and cleared by writing one to it.

Register reads are captured into the read data register and appear the cycle after the read strobe.

Top module: `rxq_csr_port`

## Requirements
- R1: A bus read at offset 0 (data register) with the queue non-empty returns the oldest stored word on bus_rdata in the following cycle and removes that word from the queue; bus_rdata holds its value in cycles with no read.
- R2: A bus read at offset 1 returns the number of stored words, zero-extended. This count drops by exactly one after each read that pops a word and never exceeds DEPTH.
- R3: Status bit 0 and the `q_empty` output are high exactly when no word is stored, and they rise in the cycle after the pop that removes the last word. Status bit 3 and the `q_full` output are high exactly when DEPTH words are stored.
- R4: Reads at any offset other than 0 (including offset 1, offset 2 and unmapped offsets) leave the queue contents, the count and the empty flag unchanged.
- R5: `peek_data` shows the head word whenever the queue is non-empty and zero when it is empty. Watching it never changes the queue.
- R6: A data-register read while the queue is empty returns zero, leaves the count at zero and sets the sticky underflow bit (status bit 1). Only reset clears this bit.
- R7: A push and a popping data read in the same cycle leave the count unchanged and keep first-in first-out order.
- R8: A push while `q_full` is high is dropped and sets the sticky overflow bit (status bit 2). Writing a word with bit 2 set to offset 2 clears it, and writing bit 2 as zero keeps it. A new overflow in the same cycle as the clear leaves the bit set.
- R9: Writes to offset 0 and offset 1 have no effect. A write to offset 2 changes nothing except the overflow clear.
- R10: After reset the queue is empty, the count reads zero, both sticky bits are clear, `q_full` is low and bus_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Ingress push strobe |
| in_data | input | DATA_W | Ingress word |
| q_full | output | 1 | Queue holds DEPTH words |
| q_empty | output | 1 | Queue holds no words |
| bus_addr | input | ADDR_W | Register offset |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after bus_rd |
| peek_data | output | DATA_W | Non-destructive view of the head word |

## Verification
An ingress push and a popping data read can fall in the same cycle. The bench provokes this collision on purpose in three states: an empty queue, where the read underflows but the push is kept; a partly filled queue, where the count must hold steady; and a full queue, where the push is dropped even though a word leaves. A second collision is an overflow in the same cycle as a write-one clear. The bench also provokes it and expects the bit to stay set. A behavioural queue model in the bench predicts every output on every clock, so any disagreement on the order of words or on the count shows up in the cycle it happens.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Register offsets; software decodes these
  localparam int unsigned OFS_DATA   = 0;
  localparam int unsigned OFS_LEVEL  = 1;
  localparam int unsigned OFS_STATUS = 2;
  // Status bit positions
  localparam int unsigned ST_EMPTY = 0;
  localparam int unsigned ST_UNDER = 1;
  localparam int unsigned ST_OVER  = 2;
  localparam int unsigned ST_FULL  = 3;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_en,
  input  logic [DATA_W-1:0] push_word,
  input  logic              pop_en,
  output logic [DATA_W-1:0] head_word,
  output logic [LVL_W-1:0]  count,
  output logic              is_empty,
  output logic              is_full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  wr_sel;
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [LVL_W-1:0]  cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  // One write enable per entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_sel
    assign wr_sel[g] = push_en && (wr_ptr_q == PTR_W'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_sel[i]) mem_q[i] <= push_word;
    end
  end

  always_comb begin
    wr_ptr_d = push_en ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop_en  ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    cnt_d    = cnt_q;
    if (push_en && !pop_en) cnt_d = cnt_q + 1'b1;
    else if (pop_en && !push_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  assign head_word = mem_q[rd_ptr_q];
  assign count     = cnt_q;
  assign is_empty  = (cnt_q == '0);
  assign is_full   = (cnt_q == LVL_W'(DEPTH));

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LVL_W'(DEPTH));
  assert_pop_drops_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && !push_en) |=> (cnt_q == $past(cnt_q) - LVL_W'(1)));
  assert_pushpop_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && push_en) |=> $stable(cnt_q));
  assert_last_pop_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && !push_en && cnt_q == LVL_W'(1)) |=> is_empty);
  assert_no_pop_when_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> !is_empty);
  assert_no_push_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> !is_full);
endmodule

// File: rtl/rxq_csr.sv
module rxq_csr
  import rxq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned LVL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              ovf_clr_bit,
  input  logic              in_valid,
  input  logic              q_empty,
  input  logic              q_full,
  input  logic [LVL_W-1:0]  q_count,
  input  logic [DATA_W-1:0] q_head,
  output logic              pop_en,
  output logic              push_en,
  output logic [DATA_W-1:0] bus_rdata
);
  logic              sel_data, sel_level, sel_status;
  logic              udf_q, udf_d, ovf_q, ovf_d;
  logic [DATA_W-1:0] rd_mux, rdata_q, status_word;

  assign sel_data   = (bus_addr == ADDR_W'(OFS_DATA));
  assign sel_level  = (bus_addr == ADDR_W'(OFS_LEVEL));
  assign sel_status = (bus_addr == ADDR_W'(OFS_STATUS));

  assign pop_en  = bus_rd && sel_data && !q_empty;
  assign push_en = in_valid && !q_full;

  always_comb begin
    status_word           = '0;
    status_word[ST_EMPTY] = q_empty;
    status_word[ST_UNDER] = udf_q;
    status_word[ST_OVER]  = ovf_q;
    status_word[ST_FULL]  = q_full;
  end

  always_comb begin
    rd_mux = '0;
    if (sel_data)        rd_mux = q_empty ? '0 : q_head;
    else if (sel_level)  rd_mux = DATA_W'(q_count);
    else if (sel_status) rd_mux = status_word;
  end

  always_comb begin
    udf_d = udf_q || (bus_rd && sel_data && q_empty);
    ovf_d = ovf_q;
    if (bus_wr && sel_status && ovf_clr_bit) ovf_d = 1'b0;
    if (in_valid && q_full) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      udf_q   <= 1'b0;
      ovf_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      udf_q <= udf_d;
      ovf_q <= ovf_d;
      if (bus_rd) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;

  assert_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel_data && q_empty) |=> (udf_q && bus_rdata == '0));
  assert_underflow_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    udf_q |=> udf_q);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && q_full) |=> ovf_q);
  assert_ovf_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_status && ovf_clr_bit && !(in_valid && q_full)) |=> !ovf_q);
  assert_rdata_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: rtl/rxq_csr_port.sv
module rxq_csr_port
  import rxq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              q_full,
  output logic              q_empty,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] peek_data
);
  localparam int unsigned LVL_W = $clog2(DEPTH + 1);

  logic              pop_en, push_en, empty_w, full_w;
  logic [LVL_W-1:0]  count_w;
  logic [DATA_W-1:0] head_w;
  logic              unused_wdata;

  assign unused_wdata = ^{bus_wdata[DATA_W-1:ST_OVER+1], bus_wdata[ST_OVER-1:0]};

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (push_en),
    .push_word (in_data),
    .pop_en    (pop_en),
    .head_word (head_w),
    .count     (count_w),
    .is_empty  (empty_w),
    .is_full   (full_w)
  );

  rxq_csr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_csr (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .ovf_clr_bit (bus_wdata[ST_OVER]),
    .in_valid    (in_valid),
    .q_empty     (empty_w),
    .q_full      (full_w),
    .q_count     (count_w),
    .q_head      (head_w),
    .pop_en      (pop_en),
    .push_en     (push_en),
    .bus_rdata   (bus_rdata)
  );

  assign q_full    = full_w;
  assign q_empty   = empty_w;
  assign peek_data = empty_w ? '0 : head_w;

  assert_other_read_keeps_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr != ADDR_W'(OFS_DATA) && !in_valid) |=> ($stable(count_w) && $stable(peek_data)));
  assert_peek_no_effect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && !in_valid) |=> ($stable(count_w) && $stable(peek_data)));
  assert_write_no_queue_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && !in_valid) |=> $stable(count_w));
  assert_empty_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty |-> (peek_data == '0));
endmodule

// File: tb/rxq_csr_port_tb.sv
`timescale 1ns/1ps
module rxq_csr_port_tb_top;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned DEPTH  = 8;
  localparam int unsigned ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic [DATA_W-1:0] in_data;
  logic              q_full, q_empty;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_rd, bus_wr;
  logic [DATA_W-1:0] bus_wdata, bus_rdata, peek_data;

  always #2 clk = ~clk;

  rxq_csr_port #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .q_full(q_full), .q_empty(q_empty), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .peek_data(peek_data)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] mq[$];
  bit          m_uf, m_of;
  logic [31:0] m_rd;

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_peek();
    return (mq.size() == 0) ? 32'h0 : mq[0];
  endfunction

  task automatic compare_all(string req);
    cmp(req, "bus_rdata", bus_rdata, m_rd);
    cmp("R3", "q_empty", {31'b0, q_empty}, {31'b0, mq.size() == 0});
    cmp("R3", "q_full", {31'b0, q_full}, {31'b0, mq.size() == DEPTH});
    cmp("R5", "peek_data", peek_data, m_peek());
  endtask

  task automatic step(bit pv, logic [31:0] pd, bit rd, bit wr,
                      logic [3:0] a, logic [31:0] wd, string req);
    int  sz;
    bit  f, e;
    @(negedge clk);
    in_valid = pv; in_data = pd; bus_rd = rd; bus_wr = wr;
    bus_addr = a;  bus_wdata = wd;
    sz = mq.size();
    f  = (sz == DEPTH);
    e  = (sz == 0);
    if (rd) begin
      case (a)
        4'd0: begin
          if (!e) m_rd = mq.pop_front();
          else begin m_rd = 32'h0; m_uf = 1'b1; end
        end
        4'd1: m_rd = 32'(sz);
        4'd2: m_rd = {28'b0, f, m_of, m_uf, e};
        default: m_rd = 32'h0;
      endcase
    end
    if (wr && a == 4'd2 && wd[2]) m_of = 1'b0;
    if (pv) begin
      if (!f) mq.push_back(pd);
      else m_of = 1'b1;
    end
    @(posedge clk);
    #1;
    compare_all(req);
  endtask

  task automatic idle(string req);
    step(1'b0, 32'h0, 1'b0, 1'b0, 4'd0, 32'h0, req);
  endtask

  task automatic push(logic [31:0] d, string req);
    step(1'b1, d, 1'b0, 1'b0, 4'd0, 32'h0, req);
  endtask

  task automatic rd(logic [3:0] a, string req);
    step(1'b0, 32'h0, 1'b1, 1'b0, a, 32'h0, req);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d, string req);
    step(1'b0, 32'h0, 1'b0, 1'b1, a, d, req);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_data = '0; bus_rd = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    m_uf = 1'b0; m_of = 1'b0; m_rd = 32'h0;
    repeat (3) @(posedge clk);
    #1;
    compare_all("R10_reset");
    @(negedge clk);
    rst_n = 1'b1;
    rd(4'd1, "R10_level_after_reset");
    rd(4'd2, "R10_status_after_reset");

    // R1 order and pop, R2 level decrement, R3 empty after last pop
    push(32'hA000_0001, "R1");
    push(32'hA000_0002, "R1");
    push(32'hA000_0003, "R1");
    rd(4'd1, "R2_level_three");
    rd(4'd0, "R1_first_word");
    rd(4'd1, "R2_level_two");
    rd(4'd0, "R1_second_word");
    rd(4'd0, "R3_last_pop");
    rd(4'd2, "R3_status_empty");
    idle("R1_rdata_hold");

    // R6 underflow
    rd(4'd0, "R6_empty_read");
    rd(4'd1, "R6_level_zero");
    rd(4'd2, "R6_underflow_bit");

    // R4 non-data reads do not pop
    push(32'hB000_0001, "R4");
    push(32'hB000_0002, "R4");
    rd(4'd1, "R4_level_read");
    rd(4'd2, "R4_status_read");
    rd(4'd5, "R4_unmapped_read");
    rd(4'd15, "R4_unmapped_read");
    rd(4'd1, "R4_level_unchanged");
    rd(4'd0, "R4_head_intact");

    // R5 peek: idle cycles, peek stays on head
    repeat (3) idle("R5_peek_stable");

    // R9 writes to data and level ignored
    wr(4'd0, 32'hDEAD_BEEF, "R9_data_write");
    wr(4'd1, 32'h0000_0007, "R9_level_write");
    rd(4'd1, "R9_level_unchanged");

    // R7 simultaneous push and pop
    step(1'b1, 32'hC000_0001, 1'b1, 1'b0, 4'd0, 32'h0, "R7_pushpop");
    step(1'b1, 32'hC000_0002, 1'b1, 1'b0, 4'd0, 32'h0, "R7_pushpop");
    rd(4'd1, "R7_level_same");
    rd(4'd0, "R7_order");
    rd(4'd0, "R7_order");
    // push and pop with an empty queue: underflow, push kept
    step(1'b1, 32'hC000_0003, 1'b1, 1'b0, 4'd0, 32'h0, "R7_empty_collision");
    rd(4'd1, "R7_level_one");
    rd(4'd0, "R7_drain");

    // R8 overflow
    for (int i = 0; i < DEPTH; i++) push(32'hD000_0000 + 32'(i), "R8_fill");
    rd(4'd2, "R8_full_status");
    push(32'hEEEE_EEEE, "R8_dropped_push");
    rd(4'd2, "R8_overflow_set");
    rd(4'd1, "R8_level_full");
    // full queue, push plus pop: push dropped
    step(1'b1, 32'hFFFF_0000, 1'b1, 1'b0, 4'd0, 32'h0, "R8_full_collision");
    wr(4'd2, 32'h0000_0000, "R8_write_zero_keeps");
    rd(4'd2, "R8_still_set");
    wr(4'd2, 32'hFFFF_FFFB, "R9_status_other_bits");
    rd(4'd2, "R9_status_unchanged");
    wr(4'd2, 32'h0000_0004, "R8_w1c");
    rd(4'd2, "R8_cleared");
    push(32'h1234_5678, "R8_refill");
    step(1'b1, 32'h1111_1111, 1'b0, 1'b1, 4'd2, 32'h4, "R8_set_wins");
    rd(4'd2, "R8_set_wins_status");
    for (int i = 0; i < DEPTH; i++) rd(4'd0, "R1_drain_order");

    // Mixed traffic
    for (int i = 0; i < 600; i++) begin
      int unsigned r = $urandom;
      logic [3:0] a;
      case (r[3:1])
        3'd0, 3'd1, 3'd2, 3'd3: a = 4'd0;
        3'd4: a = 4'd1;
        3'd5: a = 4'd2;
        default: a = 4'd6;
      endcase
      step(r[4] | r[5], $urandom, r[6], r[9:7] == 3'd0, a,
           r[10] ? 32'h4 : 32'h0, "R7_mixed");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule